// File: doc/BRIEF.md
# GPIO Output, Enable and Interrupt-Status Register Bank

This block holds the per-pin state of a 40-pin general-purpose I/O port behind a word-addressed register bus: the driven level, the drive enable and a sticky interrupt-status flag for every pin. Each of these three states has three write views. The plain view replaces a word. The set view turns on the bits written as 1. The clear view turns off the bits written as 1. Software can therefore change single pins without a read-modify-write sequence that another agent could interleave with.

Pins 0–31 occupy a full 32-bit low word. Pins 32–39 occupy bits 7:0 of a high word, and the rest of that word is reserved. The bank also returns the pad input levels, taken through a two-flop synchronizer. A per-pin driver-mode register selects push-pull or open-drain drive, and the block turns its state into pad output and pad enable levels. An interrupt detector outside the block raises status bits through a hardware set port.

Top module: `gpio_setclr_bank`

## Requirements
- R1: A write to a plain view replaces the state bits of that half (low: pins 0–31 from wdata[31:0]; high: pins 32–39 from wdata[7:0]) and leaves the other half unchanged.
- R2: A write to a set view sets each addressed state bit whose wdata bit is 1; bits written with 0 keep their value.
- R3: A write to a clear view clears each addressed state bit whose wdata bit is 1; bits written with 0 keep their value.
- R4: Reading a plain, set or clear view returns the current state of that half. Addresses 22–31 read as zero and writes to them change nothing.
- R5: Bits 31:8 of every high-half word read as zero, and writes to them are ignored.
- R6: The input words (address 18 for pins 0–31, address 19 for pins 32–39 in bits 7:0) show a pad input level at the second rising clock edge after it is applied. They still show the old level after the first edge.
- R7: For a pin in push-pull mode (driver bit 0), pad_out equals the output value bit and pad_oe equals the enable bit.
- R8: For a pin in open-drain mode (driver bit 1), pad_out is 0, and pad_oe is the enable bit ANDed with the inverted output value bit.
- R9: A 1 on irq_set sets that pin's status bit at the next edge, even when a clear-view write in the same cycle clears it.
- R10: After reset every state, driver-mode and input register is zero.
- R11: Word address = 6·kind + 3·half + view, with kind 0 output value, 1 output enable, 2 interrupt status; half 0 low, 1 high; view 0 plain, 1 set, 2 clear. Driver-mode words are at 20 (low) and 21 (high) and have a plain view only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 40 | Raw pad input levels |
| irq_set | input | 40 | Hardware set pulses for interrupt status |
| pad_out | output | 40 | Level driven to each pad |
| pad_oe | output | 40 | Drive enable for each pad |
| irq_status | output | 40 | Interrupt status flags |

## Verification
The register assertions assume that at most one word is written per cycle. The bus decode guarantees this, and the bench drives a single address per write. The latency check on the synchronizer assumes pad_in changes only away from the clock edge, so the bench changes pad inputs on falling edges. The bench applies irq_set only in the cycles it chooses, and it keeps a model of the hardware sets together with the software views. The "hardware wins" property is therefore exercised only where the bench can predict the result.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   typedef enum logic [1:0] {
      KIND_VAL = 2'd0,
      KIND_ENA = 2'd1,
      KIND_IST = 2'd2
   } state_kind_e;

   typedef enum logic [1:0] {
      VIEW_PLAIN = 2'd0,
      VIEW_SET   = 2'd1,
      VIEW_CLR   = 2'd2
   } write_view_e;

   localparam int unsigned NUM_KINDS  = 3;
   localparam int unsigned NUM_HALVES = 2;
   localparam int unsigned NUM_VIEWS  = 3;
   localparam int unsigned SYNC_LO_ADDR  = NUM_KINDS * NUM_HALVES * NUM_VIEWS;
   localparam int unsigned SYNC_HI_ADDR  = SYNC_LO_ADDR + 1;
   localparam int unsigned MODE_LO_ADDR  = SYNC_LO_ADDR + 2;
   localparam int unsigned MODE_HI_ADDR  = SYNC_LO_ADDR + 3;
   localparam int unsigned LAST_ADDR     = MODE_HI_ADDR;

   function automatic int unsigned view_addr(int unsigned kind, int unsigned half,
                                             int unsigned view);
      return kind * (NUM_HALVES * NUM_VIEWS) + half * NUM_VIEWS + view;
   endfunction

endpackage

// File: rtl/gpio_wr_decode.sv
module gpio_wr_decode
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PINS = 40,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 5
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr,
   input  logic [ADDR_W-1:0]                    addr,
   input  logic [DATA_W-1:0]                    wdata,
   output logic [NUM_KINDS-1:0][NUM_PINS-1:0]   plain_mask,
   output logic [NUM_PINS-1:0]                  wide_data,
   output logic [NUM_KINDS-1:0][NUM_PINS-1:0]   set_mask,
   output logic [NUM_KINDS-1:0][NUM_PINS-1:0]   clr_mask,
   output logic [NUM_PINS-1:0]                  mode_mask
);
   localparam int unsigned HI_W = NUM_PINS - DATA_W;

   logic [NUM_PINS-1:0] lo_span, hi_span, lo_data, hi_data;
   logic                addr_hi;

   assign lo_span = {{HI_W{1'b0}}, {DATA_W{1'b1}}};
   assign hi_span = ~lo_span;
   assign lo_data = {{HI_W{1'b0}}, wdata};
   assign hi_data = {wdata[HI_W-1:0], {DATA_W{1'b0}}};

   always_comb begin
      addr_hi = 1'b0;
      for (int unsigned k = 0; k < NUM_KINDS; k++) begin
         for (int unsigned v = 0; v < NUM_VIEWS; v++) begin
            if (int'(addr) == int'(view_addr(k, 1, v))) addr_hi = 1'b1;
         end
      end
      if (int'(addr) == int'(MODE_HI_ADDR)) addr_hi = 1'b1;
   end

   assign wide_data = addr_hi ? hi_data : lo_data;

   always_comb begin
      plain_mask = '0;
      set_mask   = '0;
      clr_mask   = '0;
      mode_mask  = '0;
      if (wr) begin
         for (int unsigned k = 0; k < NUM_KINDS; k++) begin
            for (int unsigned h = 0; h < NUM_HALVES; h++) begin
               if (int'(addr) == int'(view_addr(k, h, VIEW_PLAIN)))
                  plain_mask[k] = (h == 0) ? lo_span : hi_span;
               if (int'(addr) == int'(view_addr(k, h, VIEW_SET)))
                  set_mask[k] = (h == 0) ? lo_data : hi_data;
               if (int'(addr) == int'(view_addr(k, h, VIEW_CLR)))
                  clr_mask[k] = (h == 0) ? lo_data : hi_data;
            end
         end
         if (int'(addr) == int'(MODE_LO_ADDR)) mode_mask = lo_span;
         if (int'(addr) == int'(MODE_HI_ADDR)) mode_mask = hi_span;
      end
   end

   logic [3*NUM_KINDS:0] touched;
   always_comb begin
      for (int unsigned k = 0; k < NUM_KINDS; k++) begin
         touched[3*k]   = |plain_mask[k];
         touched[3*k+1] = |set_mask[k];
         touched[3*k+2] = |clr_mask[k];
      end
      touched[3*NUM_KINDS] = |mode_mask;
   end

   // R11: one write never lands on two views or two kinds
   assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(touched));

   // R5: reserved high bits never reach any state bit
   assert_hi_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_hi && wr) |-> ((wide_data & lo_span) == '0));

endmodule

// File: rtl/gpio_view_reg.sv
module gpio_view_reg #(
   parameter int unsigned W = 40
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] plain_mask,
   input  logic [W-1:0] plain_val,
   input  logic [W-1:0] set_mask,
   input  logic [W-1:0] clr_mask,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);
   logic [W-1:0] sw_next;

   always_comb begin
      sw_next = (q & ~plain_mask) | (plain_val & plain_mask);
      sw_next = (sw_next | set_mask) & ~clr_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= sw_next | hw_set;
   end

   assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_mask) |=> ((q & $past(set_mask)) == $past(set_mask)));

   assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_mask) |=> ((q & $past(clr_mask) & ~$past(hw_set)) == '0));

   assert_hw_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|hw_set) |=> ((q & $past(hw_set)) == $past(hw_set)));

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_mask == '0 && set_mask == '0 && clr_mask == '0 && hw_set == '0)
      |=> $stable(q));

   assert_plain_untouched_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_mask != '0 && set_mask == '0 && clr_mask == '0 && hw_set == '0)
      |=> ((q & ~$past(plain_mask)) == ($past(q) & ~$past(plain_mask))));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned W      = 40,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   initial begin
      assert (STAGES >= 2) else $fatal(1, "synchronizer needs two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

   assert_sync_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      q == $past(chain[STAGES-2]));

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
   parameter int unsigned W          = 40,
   parameter bit          OD_SUPPORT = 1'b1
) (
   input  logic [W-1:0] out_val,
   input  logic [W-1:0] out_ena,
   input  logic [W-1:0] od_sel,
   output logic [W-1:0] pad_out,
   output logic [W-1:0] pad_oe
);
   for (genvar i = 0; i < W; i++) begin : g_pin
      if (OD_SUPPORT) begin : g_od
         assign pad_out[i] = od_sel[i] ? 1'b0 : out_val[i];
         assign pad_oe[i]  = od_sel[i] ? (out_ena[i] & ~out_val[i]) : out_ena[i];
      end else begin : g_pp
         assign pad_out[i] = out_val[i];
         assign pad_oe[i]  = out_ena[i];
      end
   end

endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 40,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          OD_SUPPORT  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   input  logic [NUM_PINS-1:0] irq_set,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] irq_status
);
   localparam int unsigned HI_W  = NUM_PINS - DATA_W;
   localparam int unsigned PAD_W = DATA_W - HI_W;

   initial begin
      assert (NUM_PINS > DATA_W && NUM_PINS < 2 * DATA_W)
         else $fatal(1, "pin count must need a partial high word");
      assert ((1 << ADDR_W) > LAST_ADDR)
         else $fatal(1, "address width too small for the map");
   end

   logic [NUM_KINDS-1:0][NUM_PINS-1:0] plain_mask, set_mask, clr_mask, state;
   logic [NUM_PINS-1:0] wide_data, mode_mask, mode_q, in_sync;

   gpio_wr_decode #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .plain_mask(plain_mask), .wide_data(wide_data), .set_mask(set_mask),
      .clr_mask(clr_mask), .mode_mask(mode_mask)
   );

   for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      logic [NUM_PINS-1:0] hw;
      if (k == int'(KIND_IST)) begin : g_hw
         assign hw = irq_set;
      end else begin : g_sw
         assign hw = '0;
      end
      gpio_view_reg #(.W(NUM_PINS)) u_reg (
         .clk(clk), .rst_n(rst_n), .plain_mask(plain_mask[k]), .plain_val(wide_data),
         .set_mask(set_mask[k]), .clr_mask(clr_mask[k]), .hw_set(hw), .q(state[k])
      );
   end

   gpio_view_reg #(.W(NUM_PINS)) u_mode (
      .clk(clk), .rst_n(rst_n), .plain_mask(mode_mask), .plain_val(wide_data),
      .set_mask('0), .clr_mask('0), .hw_set('0), .q(mode_q)
   );

   gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync)
   );

   gpio_pad_drive #(.W(NUM_PINS), .OD_SUPPORT(OD_SUPPORT)) u_drv (
      .out_val(state[KIND_VAL]), .out_ena(state[KIND_ENA]), .od_sel(mode_q),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   assign irq_status = state[KIND_IST];

   function automatic logic [DATA_W-1:0] pick_half(logic [NUM_PINS-1:0] v, bit hi);
      return hi ? {{PAD_W{1'b0}}, v[NUM_PINS-1:DATA_W]} : v[DATA_W-1:0];
   endfunction

   logic rd_hi;
   always_comb begin
      bus_rdata = '0;
      rd_hi     = 1'b0;
      for (int unsigned k = 0; k < NUM_KINDS; k++) begin
         for (int unsigned h = 0; h < NUM_HALVES; h++) begin
            for (int unsigned v = 0; v < NUM_VIEWS; v++) begin
               if (int'(bus_addr) == int'(view_addr(k, h, v))) begin
                  bus_rdata = pick_half(state[k], h == 1);
                  rd_hi     = (h == 1);
               end
            end
         end
      end
      if (int'(bus_addr) == int'(SYNC_LO_ADDR)) bus_rdata = pick_half(in_sync, 1'b0);
      if (int'(bus_addr) == int'(SYNC_HI_ADDR)) begin
         bus_rdata = pick_half(in_sync, 1'b1);
         rd_hi     = 1'b1;
      end
      if (int'(bus_addr) == int'(MODE_LO_ADDR)) bus_rdata = pick_half(mode_q, 1'b0);
      if (int'(bus_addr) == int'(MODE_HI_ADDR)) begin
         bus_rdata = pick_half(mode_q, 1'b1);
         rd_hi     = 1'b1;
      end
   end

   assert_rd_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi |-> (bus_rdata[DATA_W-1:HI_W] == '0));

   assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bus_addr) > int'(LAST_ADDR)) |-> (bus_rdata == '0));

   assert_od_never_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q & pad_out) == '0);

   assert_od_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q & pad_oe & state[KIND_VAL]) == '0);

   assert_push_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (~mode_q & ((pad_out ^ state[KIND_VAL]) | (pad_oe ^ state[KIND_ENA]))) == '0);

endmodule

// File: tb/gpio_setclr_bank_test.sv
module gpio_setclr_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [39:0] pad_in = '0;
   logic [39:0] irq_set = '0;
   logic [39:0] pad_out, pad_oe, irq_status;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [39:0] m_st [3];
   logic [39:0] m_mode;
   logic [39:0] m_in;

   always #4 clk = ~clk;

   gpio_setclr_bank uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .irq_set(irq_set), .pad_out(pad_out), .pad_oe(pad_oe), .irq_status(irq_status)
   );

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(int a);
      int k, h;
      if (a < 18) begin
         k = a / 6;
         h = (a % 6) / 3;
         return h ? {24'd0, m_st[k][39:32]} : m_st[k][31:0];
      end
      case (a)
         18: return m_in[31:0];
         19: return {24'd0, m_in[39:32]};
         20: return m_mode[31:0];
         21: return {24'd0, m_mode[39:32]};
         default: return 32'd0;
      endcase
   endfunction

   function automatic void model_write(int a, logic [31:0] d);
      logic [39:0] span, wide;
      int k, h, v;
      h = (a < 18) ? (a % 6) / 3 : (a == 21);
      span = h ? 40'hFF_0000_0000 : 40'h00_FFFF_FFFF;
      wide = h ? {d[7:0], 32'd0} : {8'd0, d};
      if (a < 18) begin
         k = a / 6;
         v = a % 3;
         case (v)
            0: m_st[k] = (m_st[k] & ~span) | (wide & span);
            1: m_st[k] = m_st[k] | wide;
            default: m_st[k] = m_st[k] & ~wide;
         endcase
      end else if (a == 20 || a == 21) begin
         m_mode = (m_mode & ~span) | (wide & span);
      end
   endfunction

   task automatic bus_write(int a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1;
      bus_addr = 5'(a);
      bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic read_chk(string req, int a);
      @(negedge clk);
      bus_addr = 5'(a);
      #1;
      chk(req, {32'd0, bus_rdata}, {32'd0, exp_read(a)});
   endtask

   task automatic pad_chk(string req);
      logic [39:0] eo, ee;
      eo = m_st[0] & ~m_mode;
      ee = (m_st[1] & ~m_mode) | (m_st[1] & ~m_st[0] & m_mode);
      @(negedge clk);
      #1;
      chk(req, {24'd0, pad_out}, {24'd0, eo});
      chk(req, {24'd0, pad_oe}, {24'd0, ee});
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 3; k++) m_st[k] = '0;
      m_mode = '0;
      m_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: all words zero after reset
      for (int a = 0; a < 32; a++) read_chk("R10", a);
      chk("R10", {24'd0, pad_oe}, 64'd0);

      // R1 R2 R3 R4 R11: every kind, half and view with several patterns
      for (int k = 0; k < 3; k++) begin
         for (int h = 0; h < 2; h++) begin
            for (int v = 0; v < 3; v++) begin
               for (int p = 0; p < 3; p++) begin
                  logic [31:0] pat;
                  int a;
                  pat = 32'hA5C3_0F69 ^ (32'(p) * 32'h1357_9BDF) ^ 32'(k * 16 + h * 4 + v);
                  a = k * 6 + h * 3 + v;
                  bus_write(a, pat);
                  for (int vv = 0; vv < 3; vv++) begin
                     read_chk(v == 0 ? "R1" : (v == 1 ? "R2" : "R3"), k * 6 + h * 3 + vv);
                  end
                  read_chk("R11", k * 6 + (1 - h) * 3);
               end
            end
         end
      end

      // R2 R3: zero bits in the set and clear views leave state alone
      bus_write(0, 32'h0F0F_0F0F);
      bus_write(1, 32'h0000_0000);
      read_chk("R2", 0);
      bus_write(2, 32'h0000_0000);
      read_chk("R3", 0);

      // R5: reserved high bits
      bus_write(3, 32'hFFFF_FFFF);
      read_chk("R5", 3);
      chk("R5", {32'd0, bus_rdata}, 64'h0000_00FF);
      bus_write(10, 32'hFFFF_FF00);
      read_chk("R5", 10);
      chk("R5", {32'd0, bus_rdata}, 64'h0);

      // R4: unmapped addresses
      for (int a = 22; a < 32; a++) begin
         bus_write(a, 32'hDEAD_BEEF);
         read_chk("R4", a);
      end
      for (int a = 0; a < 22; a++) read_chk("R4", a);

      // R7 R8: drive modes across several value/enable/mode mixes
      for (int p = 0; p < 4; p++) begin
         bus_write(0, 32'h3C3C_A5A5 ^ (32'(p) * 32'h0101_0101));
         bus_write(3, 32'h0000_00C3 ^ 32'(p));
         bus_write(6, 32'hFF00_F0F0 ^ (32'(p) * 32'h1111_1111));
         bus_write(9, 32'h0000_005A);
         bus_write(20, (p == 0) ? 32'h0 : 32'h6666_9999 << p);
         bus_write(21, (p == 0) ? 32'h0 : 32'h0000_00F0 >> p);
         pad_chk(p == 0 ? "R7" : "R8");
      end
      bus_write(20, 32'hFFFF_FFFF);
      bus_write(21, 32'hFF);
      pad_chk("R8");
      read_chk("R11", 20);
      read_chk("R11", 21);

      // R6: two-edge input latency, low then high word
      for (int p = 0; p < 2; p++) begin
         logic [39:0] nv;
         nv = (p == 0) ? 40'h00_C001_D00D : 40'hA5_0000_0000;
         @(negedge clk);
         pad_in = nv;
         bus_addr = 5'(18 + p);
         @(negedge clk);
         #1;
         chk("R6", {32'd0, bus_rdata}, {32'd0, exp_read(18 + p)});
         m_in = nv;
         @(negedge clk);
         #1;
         chk("R6", {32'd0, bus_rdata}, {32'd0, exp_read(18 + p)});
      end

      // R9: hardware set beats a simultaneous software clear
      bus_write(12, 32'hFFFF_FFFF);
      bus_write(15, 32'h0000_00FF);
      @(negedge clk);
      bus_wr = 1'b1;
      bus_addr = 5'd14;
      bus_wdata = 32'hFFFF_FFFF;
      irq_set = 40'h00_0000_0021;
      @(negedge clk);
      bus_wr = 1'b0;
      irq_set = '0;
      model_write(14, 32'hFFFF_FFFF);
      m_st[2] = m_st[2] | 40'h00_0000_0021;
      read_chk("R9", 12);
      chk("R9", {24'd0, irq_status}, {24'd0, 40'hFF_0000_0021});
      @(negedge clk);
      irq_set = 40'h02_0000_0000;
      @(negedge clk);
      irq_set = '0;
      m_st[2] = m_st[2] | 40'h02_0000_0000;
      read_chk("R9", 15);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule